// File: doc/BRIEF.md
# Serial EEPROM I2C Target Model

This block models a 256-byte serial EEPROM that answers as a target on a two-wire I2C bus. The bus is not sampled continuously. A host register write carries new SCL and SDA levels into the block, and `wr_en` marks that write. Each such write is one bus event. The block compares the new levels with the levels from the previous event. From that comparison it finds START and STOP conditions, rising SCL edges and protocol errors.

All protocol progress is held in one tick counter. Ticks 1 to 9 carry the command byte and its acknowledge. The next eight ticks carry either an address byte (write command) or eight data bits driven back to the host (read command). At the end of that byte the block fetches the addressed memory byte, and the target acknowledges once more. The memory contents are fixed by parameters: they are a linear function of the address. They are available from reset, and the block never writes them.

Top module: `seeprom_tgt`

## Requirements
- R1: In an event where both the previous and the new SCL are high and SDA changes, the event is a bus condition. An SDA fall is a START and arms the tick counter for a new command. An SDA rise is a STOP and returns the block to idle. Both clear any pending acknowledge and release `sda_out`.
- R2: While idle (tick counter zero, no acknowledge pending), every event other than a START leaves the block's state and `sda_out` unchanged.
- R3: State changes only on a cycle with `wr_en` high. An event whose SCL goes from low to high with SDA unchanged samples exactly one bit.
- R4: The first 8 sampled bits after a START form the command byte, MSB first. The next rising SCL edge is an acknowledge slot, in which the target drives `sda_out` low.
- R5: Bit 0 of the command byte (the last bit sent) selects the direction: 1 is read and 0 is write.
- R6: After a write command and its acknowledge, the next 8 sampled bits form the address, MSB first. After the 8th bit, the byte at that address is fetched. The next rising edge is an acknowledge (`sda_out` low), and the block then returns to idle.
- R7: After a read command and its acknowledge, each of the next 8 rising SCL edges places one bit of the fetched byte on `sda_out`, MSB first. The host keeps SDA high during these edges. After the 8th bit, the address advances by one and the byte at the new address is fetched. The next rising edge is a target acknowledge (low).
- R8: The memory byte at address a is (a × ROM_MUL + ROM_ADD) mod 256.
- R9: A driven level (acknowledge low or read-data bit) set at a rising SCL edge holds through the following SCL-low events. It changes only at the next non-idle rising edge or at a START or STOP.
- R10: An event where SCL rises and SDA also changes is a protocol error. `proto_err` is high for that event, cleared by the next event, and no bit is shifted and the tick counter does not move.
- R11: `sda_out` behaves as an open-drain target. It is high (released) after reset and at all times except while acknowledging or while sending a read-data 0. `proto_err` is low after reset.
- R12: The address is 8 bits wide, so a read at address 255 advances the address to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Host register write strobe; one bus event per cycle high |
| scl_in | input | 1 | SCL level written by the host |
| sda_in | input | 1 | SDA level written by the host |
| sda_out | output | 1 | SDA level driven by the target (1 = released) |
| proto_err | output | 1 | High after an event where SDA changed as SCL rose |

## Verification
The bench builds the block with ADDR_W = 8, ROM_MUL = 37 and ROM_ADD = 0xC3. Because the multiplier is odd, every address maps to a distinct byte, so a fetch from a neighbouring address gives a visible mismatch. The 8-bit address lets a write to address 255 followed by two reads show the wrap to address 0 in a few hundred events. The same configuration also covers a STOP in the middle of a command, idle rising edges that must be ignored, and a glitched SCL edge that must not advance the byte.

// File: rtl/seeprom_tgt.sv
module seeprom_tgt #(
  parameter int ADDR_W = 8,
  parameter logic [7:0] ROM_MUL = 8'h1D,
  parameter logic [7:0] ROM_ADD = 8'h5B
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_out,
  output logic proto_err
);
  localparam int BYTE_BITS = 8;
  localparam int TICK_W = $clog2(2 * BYTE_BITS + 1);
  localparam logic [TICK_W-1:0] T_CMD  = TICK_W'(BYTE_BITS);
  localparam logic [TICK_W-1:0] T_LAST = TICK_W'(2 * BYTE_BITS);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic              scl_q, sda_q, ack, drv;
  logic [TICK_W-1:0] tick;
  logic [7:0]        cmd, data;
  logic [ADDR_W-1:0] addr, addr_nx;

  function automatic logic [7:0] rom_byte(input logic [ADDR_W-1:0] a);
    logic [7:0] r;
    r = 8'(a) * ROM_MUL + ROM_ADD;
    return r;
  endfunction

  wire bus_cond = scl_q & scl_in & (sda_q ^ sda_in);
  wire idle     = (tick == '0) & ~ack;
  wire rise     = ~scl_q & scl_in;
  wire same     = (sda_q == sda_in);

  assign addr_nx = cmd[0] ? addr + ONE : {addr[ADDR_W-2:0], sda_in};
  assign sda_out = ~drv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1; sda_q <= 1'b1;
      tick <= '0; ack <= 1'b0; drv <= 1'b0;
      cmd <= '0; data <= '0; addr <= '0;
      proto_err <= 1'b0;
    end else if (wr_en) begin
      scl_q <= scl_in;
      sda_q <= sda_in;
      proto_err <= 1'b0;
      if (bus_cond) begin
        tick <= sda_in ? '0 : ONE[TICK_W-1:0];
        ack  <= 1'b0;
        drv  <= 1'b0;
      end else if (!idle && rise) begin
        if (ack) begin
          drv <= 1'b1;
          ack <= 1'b0;
        end else if (!same) begin
          proto_err <= 1'b1;
        end else if (tick <= T_CMD) begin
          drv  <= 1'b0;
          cmd  <= {cmd[6:0], sda_in};
          tick <= tick + 1'b1;
          if (tick == T_CMD) ack <= 1'b1;
        end else begin
          drv <= cmd[0] & ~data[7];
          if (!cmd[0]) addr <= addr_nx;
          if (tick == T_LAST) begin
            data <= rom_byte(addr_nx);
            ack  <= 1'b1;
            tick <= '0;
            if (cmd[0]) addr <= addr_nx;
          end else begin
            data <= {data[6:0], 1'b0};
            tick <= tick + 1'b1;
          end
        end
      end
    end
  end

  AST_COND_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_cond) |=> (sda_out && !ack)); // R1
  AST_IDLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idle && !bus_cond) |=> ($stable(tick) && $stable(cmd) && $stable(addr) && $stable(data) && $stable(sda_out))); // R2
  AST_NO_EVENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> ($stable(sda_out) && $stable(tick) && $stable(proto_err))); // R3
  AST_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ack && rise) |=> (!sda_out && !ack)); // R9
  AST_GLITCH_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rise && !same && !idle && !ack) |=> (proto_err && $stable(tick) && $stable(cmd))); // R10
  AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    tick <= T_LAST); // R6
endmodule

// File: tb/seeprom_tgt_bench.sv
module seeprom_tgt_bench;
  localparam logic [7:0] MUL = 8'd37;
  localparam logic [7:0] ADD = 8'hC3;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, scl = 1'b1, sda = 1'b1;
  logic sda_out, proto_err;
  logic wr_q = 1'b0;
  logic cur = 1'b1;
  int n_chk = 0, n_bad = 0;
  logic  exp_sda_q[$];
  logic  exp_err_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  seeprom_tgt #(.ADDR_W(8), .ROM_MUL(MUL), .ROM_ADD(ADD)) u_seeprom_tgt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .scl_in(scl), .sda_in(sda),
    .sda_out(sda_out), .proto_err(proto_err));

  function automatic logic [7:0] mem_at(input logic [7:0] a);
    logic [7:0] v;
    v = a * MUL + ADD;
    return v;
  endfunction

  always @(posedge clk) wr_q <= wr_en;

  always @(negedge clk) begin
    if (wr_q) begin
      if (exp_sda_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL scoreboard empty: event with no expectation");
      end else begin
        logic  es, ee;
        string t;
        es = exp_sda_q.pop_front();
        ee = exp_err_q.pop_front();
        t  = tag_q.pop_front();
        n_chk++;
        if (sda_out !== es || proto_err !== ee) begin
          n_bad++;
          $display("FAIL %s: sda_out=%b proto_err=%b, expected sda_out=%b proto_err=%b",
                   t, sda_out, proto_err, es, ee);
        end
      end
    end
  end

  task automatic ev(input logic s, input logic d, input logic es, input logic ee, input string t);
    @(negedge clk);
    scl = s; sda = d; wr_en = 1'b1;
    exp_sda_q.push_back(es); exp_err_q.push_back(ee); tag_q.push_back(t);
    cur = es;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bit_(input logic b, input logic er, input string t);
    ev(1'b0, b, cur, 1'b0, t);
    ev(1'b1, b, er, 1'b0, t);
    ev(1'b0, b, er, 1'b0, t);
  endtask

  task automatic start_(input string t);
    ev(1'b0, 1'b1, cur, 1'b0, t);
    ev(1'b1, 1'b1, cur, 1'b0, t);
    ev(1'b1, 1'b0, 1'b1, 1'b0, t);
    ev(1'b0, 1'b0, 1'b1, 1'b0, t);
  endtask

  task automatic stop_(input logic mid, input string t);
    ev(1'b0, 1'b0, cur, 1'b0, t);
    ev(1'b1, 1'b0, mid, 1'b0, t);
    ev(1'b1, 1'b1, 1'b1, 1'b0, t);
  endtask

  task automatic byte_out(input logic [7:0] b, input string t);
    for (int i = 7; i >= 0; i--) bit_(b[i], 1'b1, t);
  endtask

  task automatic byte_in(input logic [7:0] e, input string t);
    for (int i = 7; i >= 0; i--) bit_(1'b1, e[i], t);
  endtask

  task automatic set_addr(input logic [7:0] a);
    start_("R1 start");
    byte_out(8'hA0, "R5 write cmd");
    bit_(1'b1, 1'b0, "R4 cmd ack");
    byte_out(a, "R6 address");
    bit_(1'b1, 1'b0, "R6 addr ack");
    stop_(1'b0, "R1 stop idle");
  endtask

  task automatic read_byte(input logic [7:0] e, input string t);
    start_("R1 start");
    byte_out(8'hA1, "R5 read cmd");
    bit_(1'b1, 1'b0, "R4 cmd ack");
    byte_in(e, t);
    bit_(1'b1, 1'b0, "R7 read ack");
    stop_(1'b0, "R1 stop idle");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    n_chk++;
    if (sda_out !== 1'b1 || proto_err !== 1'b0) begin
      n_bad++;
      $display("FAIL R11 reset: sda_out=%b proto_err=%b, expected 1 0", sda_out, proto_err);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R8 R7: sequential reads after setting address
    set_addr(8'h10);
    read_byte(mem_at(8'h10), "R8 data 0x10");
    read_byte(mem_at(8'h11), "R7 next byte 0x11");

    // R12: wrap from 255 to 0
    set_addr(8'hFF);
    read_byte(mem_at(8'hFF), "R12 data 0xFF");
    read_byte(mem_at(8'h00), "R12 wrapped 0x00");

    // R1 STOP mid-command, then R2 idle edges ignored
    start_("R1 start");
    bit_(1'b1, 1'b1, "R1 partial");
    bit_(1'b0, 1'b1, "R1 partial");
    bit_(1'b1, 1'b1, "R1 partial");
    stop_(1'b1, "R1 stop mid cmd");
    for (int k = 0; k < 9; k++) begin
      ev(1'b0, 1'b0, 1'b1, 1'b0, "R2 idle fall");
      ev(1'b1, 1'b0, 1'b1, 1'b0, "R2 idle rise ignored");
    end
    set_addr(8'h30);
    read_byte(mem_at(8'h30), "R3 recovery data 0x30");

    // R10: SDA change with rising SCL is flagged and not counted
    start_("R1 start");
    bit_(1'b1, 1'b1, "R10 cmd");
    bit_(1'b0, 1'b1, "R10 cmd");
    ev(1'b1, 1'b1, 1'b1, 1'b1, "R10 glitch flagged");
    ev(1'b0, 1'b1, 1'b1, 1'b0, "R10 flag cleared");
    bit_(1'b1, 1'b1, "R10 cmd");
    for (int k = 0; k < 5; k++) bit_(1'b0, 1'b1, "R10 cmd");
    bit_(1'b1, 1'b0, "R10 ack on 9th valid edge");
    byte_out(8'h20, "R6 address");
    bit_(1'b1, 1'b0, "R9 addr ack");
    ev(1'b0, 1'b0, 1'b0, 1'b0, "R9 ack held low");
    stop_(1'b0, "R1 stop idle");
    read_byte(mem_at(8'h20), "R10 data 0x20");

    repeat (4) @(negedge clk);
    if (exp_sda_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL scoreboard: %0d expectations left, expected 0", exp_sda_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule